// File: doc/BRIEF.md
# Exception-Vector Window Remap Decoder

This block turns a 32-bit processor address into a physical target and an offset inside that target. The targets are an on-chip flash array (128 KB), an on-chip SRAM array (16 KB), an 8 KB boot-code block that occupies the top of flash, and a peripheral space. Addresses that fall in none of these raise an error flag. The decode is purely combinational. The only storage is a two-bit vector-mode register.

The lowest 64 bytes of the address map form the exception-vector window. It is the only region whose meaning changes with the mode. After reset the window shows the first 64 bytes of the boot block. The same bytes are then also visible at flash offset 0x1E000 and at the high alias 0x7FFFE000. Software may later point the window at flash's own first 64 bytes or at the first 64 bytes of SRAM, for example to keep exceptions serviceable while flash is busy being programmed. The boot block stays visible at its high alias in every mode.

The mode register is a small state machine with three named states. **VM_BOOT** is the reset state, and the window reads the boot vectors. **VM_UFLASH** makes the window read flash offsets 0x00–0x3F. **VM_USRAM** makes the window read SRAM offsets 0x00–0x3F. When `vmode_we` is high on a clock edge, the machine moves from any state to the state selected by `vmode_wdata`: 01 goes to VM_UFLASH, 10 goes to VM_USRAM, and 00 or 11 goes to VM_BOOT. When `vmode_we` is low, the machine stays in its current state.

Top module: `vw_remap_decoder`

## Requirements
- R1: The target select uses this encoding: 0 = none, 1 = flash, 2 = SRAM, 3 = boot block, 4 = peripheral. An address from 0x40000000 to 0x40003FFF gives select 2 with offset = address − 0x40000000, in every mode.
- R2: An address from 0x00000040 to 0x0001FFFF gives select 1 with offset = address, in every mode.
- R3: An address from 0x7FFFE000 to 0x7FFFFFFF gives select 3 with offset = address − 0x7FFFE000, in every mode.
- R4: An address from 0xE0000000 to 0xFFFFFFFF gives select 4 with offset = address − 0xE0000000, in every mode.
- R5: Any other address gives select 0, offset 0 and error = 1. For every address inside a listed region, error = 0.
- R6: After reset the mode is boot vectors. An address from 0x00 to 0x3F then gives select 3 with offset = address, which is the same data as flash offset 0x1E000 + address.
- R7: In mode 01 (user flash), an address from 0x00 to 0x3F gives select 1 with offset = address.
- R8: In mode 10 (user SRAM), an address from 0x00 to 0x3F gives select 2 with offset = address.
- R9: Writing mode value 11 has the same effect as writing 00: the window returns to the boot vectors.
- R10: A mode write takes effect from the clock cycle after the edge on which `vmode_we` is high. When `vmode_we` is low, the mode does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the mode register |
| rst_n | input | 1 | Asynchronous active-low reset |
| vmode_we | input | 1 | Mode write enable |
| vmode_wdata | input | 2 | New mode value |
| addr | input | 32 | Processor address |
| tgt_sel | output | 3 | Target select (encoding in R1) |
| tgt_off | output | 32 | Byte offset within the selected target |
| addr_err | output | 1 | High when the address maps to no target |

## Verification
The bench probes each region edge from both sides. If a design put the window limit at 0x40 instead of 0x3F, the last vector would move to flash, or the first word after the window would be swapped. If a region comparison were off by one, a hole address such as 0x00020000, 0x40004000 or 0x7FFFDFFF would leak into a neighbouring target instead of raising the error flag. The bench writes the reserved value 11 to catch a design that leaves the window on SRAM or flash. It also checks the window in the same cycle as a write and in the cycle after it, to catch a mode change that appears too early or never sticks.

// File: rtl/vw_pkg.sv
package vw_pkg;
    typedef enum logic [2:0] {
        TGT_NONE   = 3'd0,
        TGT_FLASH  = 3'd1,
        TGT_SRAM   = 3'd2,
        TGT_BOOT   = 3'd3,
        TGT_PERIPH = 3'd4
    } tgt_e;

    typedef enum logic [1:0] {
        VM_BOOT   = 2'b00,
        VM_UFLASH = 2'b01,
        VM_USRAM  = 2'b10
    } vmode_e;

    typedef struct packed {
        logic in_vec;
        logic in_flash;
        logic in_sram;
        logic in_boot;
        logic in_periph;
    } hit_t;
endpackage

// File: rtl/vw_mode_reg.sv
module vw_mode_reg
    import vw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [1:0] wdata,
    output vmode_e     mode
);
    vmode_e cur_q, nxt_c;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= VM_BOOT;
        else        cur_q <= nxt_c;
    end

    // Any state may move to any other; the reserved code falls back to boot.
    always_comb begin
        nxt_c = cur_q;
        if (we) begin
            unique case (wdata)
                2'b01:   nxt_c = VM_UFLASH;
                2'b10:   nxt_c = VM_USRAM;
                default: nxt_c = VM_BOOT;
            endcase
        end
    end

    assign mode = cur_q;
endmodule

// File: rtl/vw_region_decode.sv
module vw_region_decode
    import vw_pkg::*;
#(
    parameter logic [31:0] FLASH_BYTES = 32'h0002_0000,
    parameter logic [31:0] SRAM_BASE   = 32'h4000_0000,
    parameter logic [31:0] SRAM_BYTES  = 32'h0000_4000,
    parameter logic [31:0] BOOT_BASE   = 32'h7FFF_E000,
    parameter logic [31:0] BOOT_BYTES  = 32'h0000_2000,
    parameter logic [31:0] PERIPH_BASE = 32'hE000_0000,
    parameter logic [31:0] VEC_BYTES   = 32'h0000_0040
) (
    input  logic [31:0] addr,
    output hit_t        hit
);
    localparam logic [31:0] SRAM_LAST = SRAM_BASE + SRAM_BYTES - 32'd1;
    localparam logic [31:0] BOOT_LAST = BOOT_BASE + BOOT_BYTES - 32'd1;

    always_comb begin
        hit.in_vec    = (addr < VEC_BYTES);
        hit.in_flash  = (addr < FLASH_BYTES);
        hit.in_sram   = (addr >= SRAM_BASE) && (addr <= SRAM_LAST);
        hit.in_boot   = (addr >= BOOT_BASE) && (addr <= BOOT_LAST);
        hit.in_periph = (addr >= PERIPH_BASE);
    end
endmodule

// File: rtl/vw_target_mux.sv
module vw_target_mux
    import vw_pkg::*;
#(
    parameter logic [31:0] SRAM_BASE   = 32'h4000_0000,
    parameter logic [31:0] BOOT_BASE   = 32'h7FFF_E000,
    parameter logic [31:0] PERIPH_BASE = 32'hE000_0000
) (
    input  logic [31:0] addr,
    input  hit_t        hit,
    input  vmode_e      mode,
    output tgt_e        sel,
    output logic [31:0] off,
    output logic        err
);
    always_comb begin
        sel = TGT_NONE;
        off = '0;
        err = 1'b0;
        if (hit.in_vec) begin
            // Window offset equals the address in every source.
            off = addr;
            unique case (mode)
                VM_UFLASH: sel = TGT_FLASH;
                VM_USRAM:  sel = TGT_SRAM;
                default:   sel = TGT_BOOT;
            endcase
        end else if (hit.in_flash) begin
            sel = TGT_FLASH;
            off = addr;
        end else if (hit.in_sram) begin
            sel = TGT_SRAM;
            off = addr - SRAM_BASE;
        end else if (hit.in_boot) begin
            sel = TGT_BOOT;
            off = addr - BOOT_BASE;
        end else if (hit.in_periph) begin
            sel = TGT_PERIPH;
            off = addr - PERIPH_BASE;
        end else begin
            err = 1'b1;
        end
    end
endmodule

// File: rtl/vw_remap_decoder.sv
module vw_remap_decoder
    import vw_pkg::*;
#(
    parameter logic [31:0] FLASH_BYTES = 32'h0002_0000,
    parameter logic [31:0] SRAM_BASE   = 32'h4000_0000,
    parameter logic [31:0] SRAM_BYTES  = 32'h0000_4000,
    parameter logic [31:0] BOOT_BASE   = 32'h7FFF_E000,
    parameter logic [31:0] BOOT_BYTES  = 32'h0000_2000,
    parameter logic [31:0] PERIPH_BASE = 32'hE000_0000,
    parameter logic [31:0] VEC_BYTES   = 32'h0000_0040
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        vmode_we,
    input  logic [1:0]  vmode_wdata,
    input  logic [31:0] addr,
    output logic [2:0]  tgt_sel,
    output logic [31:0] tgt_off,
    output logic        addr_err
);
    vmode_e mode;
    hit_t   hit;
    tgt_e   sel;

    vw_mode_reg u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (vmode_we),
        .wdata (vmode_wdata),
        .mode  (mode)
    );

    vw_region_decode #(
        .FLASH_BYTES (FLASH_BYTES),
        .SRAM_BASE   (SRAM_BASE),
        .SRAM_BYTES  (SRAM_BYTES),
        .BOOT_BASE   (BOOT_BASE),
        .BOOT_BYTES  (BOOT_BYTES),
        .PERIPH_BASE (PERIPH_BASE),
        .VEC_BYTES   (VEC_BYTES)
    ) u_region (
        .addr (addr),
        .hit  (hit)
    );

    vw_target_mux #(
        .SRAM_BASE   (SRAM_BASE),
        .BOOT_BASE   (BOOT_BASE),
        .PERIPH_BASE (PERIPH_BASE)
    ) u_mux (
        .addr (addr),
        .hit  (hit),
        .mode (mode),
        .sel  (sel),
        .off  (tgt_off),
        .err  (addr_err)
    );

    assign tgt_sel = sel;
endmodule

// File: rtl/vw_remap_chk.sv
module vw_remap_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        vmode_we,
    input logic [1:0]  vmode_wdata,
    input logic [31:0] addr,
    input logic [2:0]  tgt_sel,
    input logic [31:0] tgt_off,
    input logic        addr_err
);
    // R1
    sram_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr >= 32'h4000_0000 && addr <= 32'h4000_3FFF)
        |-> (tgt_sel == 3'd2 && tgt_off == addr - 32'h4000_0000));

    // R2
    flash_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr >= 32'h40 && addr <= 32'h1_FFFF)
        |-> (tgt_sel == 3'd1 && tgt_off == addr));

    // R3
    boot_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr >= 32'h7FFF_E000)  && (addr <= 32'h7FFF_FFFF)
        |-> (tgt_sel == 3'd3 && tgt_off == addr - 32'h7FFF_E000));

    // R4
    periph_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr >= 32'hE000_0000) |-> (tgt_sel == 3'd4 && !addr_err));

    // R5
    err_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err |-> (tgt_sel == 3'd0 && tgt_off == 32'd0));

    // R10
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr < 32'h40 && $past(addr) < 32'h40 && !$past(vmode_we))
        |-> (tgt_sel == $past(tgt_sel)));
endmodule

bind vw_remap_decoder vw_remap_chk u_chk (.*);

// File: tb/vw_remap_decoder_bench.sv
module vw_remap_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vmode_we = 1'b0;
    logic [1:0]  vmode_wdata = 2'b00;
    logic [31:0] addr = 32'd0;
    logic [2:0]  tgt_sel;
    logic [31:0] tgt_off;
    logic        addr_err;

    int total = 0;
    int bad = 0;
    int mode_m = 0;     // reference mode: 0 boot, 1 user flash, 2 user SRAM
    bit last_was_11 = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    vw_remap_decoder u_vw_remap_decoder (
        .clk(clk), .rst_n(rst_n), .vmode_we(vmode_we), .vmode_wdata(vmode_wdata),
        .addr(addr), .tgt_sel(tgt_sel), .tgt_off(tgt_off), .addr_err(addr_err)
    );

    // Behavioural reference: region table from the requirements.
    task automatic expect_for(input logic [31:0] a, output int s, output logic [31:0] o,
                              output bit e, output string tag);
        e = 1'b0;
        if (a < 32'h40) begin
            o = a;
            if (mode_m == 1)      begin s = 1; tag = "R7"; end
            else if (mode_m == 2) begin s = 2; tag = "R8"; end
            else begin s = 3; tag = last_was_11 ? "R9" : "R6"; end
        end else if (a < 32'h2_0000) begin s = 1; o = a; tag = "R2"; end
        else if (a >= 32'h4000_0000 && a < 32'h4000_4000) begin
            s = 2; o = a - 32'h4000_0000; tag = "R1";
        end else if (a >= 32'h7FFF_E000 && a < 32'h8000_0000) begin
            s = 3; o = a - 32'h7FFF_E000; tag = "R3";
        end else if (a >= 32'hE000_0000) begin
            s = 4; o = a - 32'hE000_0000; tag = "R4";
        end else begin s = 0; o = 32'd0; e = 1'b1; tag = "R5"; end
    endtask

    task automatic compare(input string extra);
        int s; logic [31:0] o; bit e; string tag;
        expect_for(addr, s, o, e, tag);
        total++;
        if (tgt_sel !== 3'(s) || tgt_off !== o || addr_err !== e) begin
            bad++;
            $display("FAIL %s%s addr=%h: sel=%0d off=%h err=%0b expected sel=%0d off=%h err=%0b",
                     tag, extra, addr, tgt_sel, tgt_off, addr_err, s, o, e);
        end
    endtask

    // One cycle: drive after the falling edge, check, then let the rising edge commit.
    task automatic step(input logic [31:0] a, input bit we, input logic [1:0] wd);
        @(negedge clk);
        addr = a; vmode_we = we; vmode_wdata = wd;
        #1;
        compare(we ? " (R10 same cycle)" : "");
        @(posedge clk);
        if (we) begin
            mode_m = (wd == 2'b01) ? 1 : (wd == 2'b10) ? 2 : 0;
            last_was_11 = (wd == 2'b11);
        end
        #1;
        vmode_we = 1'b0;
    endtask

    task automatic sweep();
        logic [31:0] pts [18] = '{32'h0, 32'h3C, 32'h3F, 32'h40, 32'h1_E000, 32'h1_E03F,
            32'h1_FFFF, 32'h2_0000, 32'h3FFF_FFFF, 32'h4000_0000, 32'h4000_3FFF,
            32'h4000_4000, 32'h7FFF_DFFF, 32'h7FFF_E000, 32'h7FFF_FFFF,
            32'h8000_0000, 32'hDFFF_FFFF, 32'hFFFF_FFFF};
        foreach (pts[i]) step(pts[i], 1'b0, 2'b00);
    endtask

    initial begin
        logic [31:0] lfsr;
        lfsr = 32'hACE1_1234;
        // Reset state: window shows boot vectors (R6)
        #3;
        addr = 32'h10;
        #1;
        compare(" (reset)");
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        sweep();                      // R6, R1-R5 in boot mode
        step(32'h0, 1'b1, 2'b01);     // write user flash, same-cycle still boot
        step(32'h0, 1'b0, 2'b00);     // R7/R10 next cycle
        sweep();
        step(32'h20, 1'b1, 2'b10);
        sweep();                      // R8
        step(32'h3F, 1'b1, 2'b11);
        sweep();                      // R9
        step(32'h4, 1'b1, 2'b10);
        step(32'h4, 1'b1, 2'b00);
        step(32'h4, 1'b0, 2'b10);     // no write: data ignored (R10)
        step(32'h8, 1'b0, 2'b01);
        for (int k = 0; k < 400; k++) begin
            bit w;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            w = (lfsr[7:4] == 4'd0);
            case (lfsr[2:0])
                3'd0, 3'd1: step({26'd0, lfsr[13:8]}, w, lfsr[15:14]);
                3'd2:       step({15'd0, lfsr[24:8]}, w, lfsr[15:14]);
                3'd3:       step({18'h1_0000, lfsr[21:8]}, w, lfsr[15:14]);
                3'd4:       step({19'h3_FFFF, lfsr[20:8]}, w, lfsr[15:14]);
                default:    step(lfsr, w, lfsr[15:14]);
            endcase
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #100000;
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule